// File: doc/BRIEF.md
# Async HDLC Transmit Framer

This block turns an outgoing packet into a byte-stuffed asynchronous HDLC octet stream of the kind that PPP uses over a serial line. The packet arrives as a valid/ready byte stream. A last marker ends the packet, and the packet's declared length sits on a sideband bus alongside the first byte. The block wraps the packet in flag octets and escapes the octets that the far end must not see raw. It appends a 16-bit frame check sequence computed over the unstuffed payload. The result goes out on a valid/ready octet stream toward a UART.

Two configuration registers set the framing. One is a 32-bit control-character escape mask. The other is a maximum packet length. If a packet's declared length is above the maximum, no frame is sent. Instead the block drains the packet from its input and raises a one-cycle reject pulse. Backpressure from the UART side can stall the output at any octet, including between the two halves of an escape pair.

Top module: `hdlc_async_framer`

## Requirements
- R1: Every accepted packet produces a frame that starts with one flag octet 0x7E and ends with one flag octet 0x7E, with nothing between frames.
- R2: A payload octet below 0x20 whose bit in the escape mask is set (bit index equals the octet value) is sent as 0x7D followed by the octet XOR 0x20. If that mask bit is clear, the octet is sent unchanged.
- R3: The octets 0x7E and 0x7D are always sent as 0x7D followed by the octet XOR 0x20, whatever the mask holds.
- R4: The check sequence is the reflected CRC-16 (polynomial 0x8408, start value 0xFFFF) over the unescaped payload octets. Its ones complement follows the last payload octet, low byte first. For the payload "123456789" the two trailer octets are 0x6E then 0x90.
- R5: Both trailer octets pass through the same escaping rules as payload octets (R2, R3).
- R6: A packet whose declared length exceeds the maximum length produces no output octet. All of its bytes up to and including the last are accepted. The reject output is high for exactly one cycle, the cycle after the last byte is taken.
- R7: A packet whose declared length equals the maximum length is framed normally.
- R8: After reset, out_valid, reject and in_ready are low, the escape mask is 0xFFFFFFFF, and the maximum length is 1500.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged. No octet is lost or duplicated under any pattern of out_ready.
- R10: Payload octets at or above 0x20, other than 0x7E and 0x7D, are sent unchanged whatever the mask holds.
- R11: A write to the mask or maximum-length register takes effect for packets that start after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_accm_we | input | 1 | Write strobe for the escape mask |
| cfg_accm | input | 32 | New escape mask value |
| cfg_mru_we | input | 1 | Write strobe for the maximum length |
| cfg_mru | input | 16 | New maximum packet length in bytes |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of the packet |
| in_len | input | 16 | Declared packet length, valid with the first byte |
| out_valid | output | 1 | Line octet valid |
| out_ready | input | 1 | Line side can take an octet |
| out_data | output | 8 | Line octet |
| reject | output | 1 | One-cycle pulse after an oversize packet is drained |

## Verification
A wrong escape decision or a wrong hold register shows up in the octet that follows 0x7D, in the same frame where it happens. A corrupted check-sequence register shows only in the two trailer octets at the end of the frame. For that reason every frame is compared in full against a model, including frames whose trailer itself needs escaping. A state machine that loses its return point after an escape pair would drop or repeat octets in the next frame. Random stalls on out_ready are applied throughout, so such faults appear as a length or content mismatch within a few octets.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam logic [7:0]  FLAG_OCT  = 8'h7E;
    localparam logic [7:0]  ESC_OCT   = 8'h7D;
    localparam logic [7:0]  XOR_MASK  = 8'h20;
    localparam logic [15:0] FCS_START = 16'hFFFF;
    localparam logic [15:0] FCS_POLY  = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_ESC2,
        ST_FCSL,
        ST_FCSH,
        ST_CLOSE,
        ST_DRAIN
    } fr_state_e;

    typedef struct packed {
        fr_state_e  st;
        fr_state_e  ret;
        logic [7:0] hold;
        logic       rej;
    } fr_regs_t;

    // one octet through the reflected CRC-16, least significant bit first
    function automatic logic [15:0] fcs_step(input logic [15:0] crc, input logic [7:0] b);
        logic [15:0] c;
        c = crc;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ FCS_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlc_cfg_regs.sv
module hdlc_cfg_regs #(
    parameter int ACCM_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MRU_RESET = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accm_we,
    input  logic [ACCM_W-1:0] accm_wdata,
    input  logic              mru_we,
    input  logic [LEN_W-1:0]  mru_wdata,
    output logic [ACCM_W-1:0] accm,
    output logic [LEN_W-1:0]  mru
);

    typedef struct packed {
        logic [ACCM_W-1:0] accm;
        logic [LEN_W-1:0]  mru;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (accm_we) cfg_d.accm = accm_wdata;
        if (mru_we)  cfg_d.mru  = mru_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.accm <= '1;
            cfg_q.mru  <= LEN_W'(MRU_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign accm = cfg_q.accm;
    assign mru  = cfg_q.mru;

    assert_accm_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accm_we |=> (accm == $past(accm_wdata)));

    assert_mru_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mru_we |=> $stable(mru));

endmodule

// File: rtl/hdlc_esc_decide.sv
module hdlc_esc_decide #(
    parameter int ACCM_W = 32
) (
    input  logic [7:0]        byte_i,
    input  logic [ACCM_W-1:0] accm_i,
    output logic              esc_o
);
    import hdlc_tx_pkg::*;

    localparam int IDX_W = (ACCM_W > 1) ? $clog2(ACCM_W) : 1;

    logic in_range;
    logic mapped;

    assign in_range = (32'(byte_i) < ACCM_W);
    assign mapped   = in_range && accm_i[byte_i[IDX_W-1:0]];
    assign esc_o    = mapped || (byte_i == FLAG_OCT) || (byte_i == ESC_OCT);

endmodule

// File: rtl/hdlc_fcs_unit.sv
module hdlc_fcs_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        upd_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] fcs_o
);
    import hdlc_tx_pkg::*;

    logic [15:0] fcs_d, fcs_q;

    always_comb begin
        fcs_d = fcs_q;
        if (init_i)     fcs_d = FCS_START;
        else if (upd_i) fcs_d = fcs_step(fcs_q, byte_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fcs_q <= FCS_START;
        else        fcs_q <= fcs_d;
    end

    assign fcs_o = fcs_q;

    assert_init_upd_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_i && upd_i));

    assert_fcs_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !upd_i) |=> $stable(fcs_o));

endmodule

// File: rtl/hdlc_async_framer.sv
module hdlc_async_framer #(
    parameter int ACCM_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MRU_RESET = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_accm_we,
    input  logic [ACCM_W-1:0] cfg_accm,
    input  logic              cfg_mru_we,
    input  logic [LEN_W-1:0]  cfg_mru,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [LEN_W-1:0]  in_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              reject
);
    import hdlc_tx_pkg::*;

    logic [ACCM_W-1:0] accm;
    logic [LEN_W-1:0]  mru;
    logic [15:0]       fcs;
    logic [15:0]       fcs_inv;
    logic [7:0]        esc_byte;
    logic              esc_need;
    logic              fcs_init;
    logic              fcs_upd;

    fr_regs_t r_d, r_q;

    hdlc_cfg_regs #(
        .ACCM_W   (ACCM_W),
        .LEN_W    (LEN_W),
        .MRU_RESET(MRU_RESET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .accm_we   (cfg_accm_we),
        .accm_wdata(cfg_accm),
        .mru_we    (cfg_mru_we),
        .mru_wdata (cfg_mru),
        .accm      (accm),
        .mru       (mru)
    );

    hdlc_esc_decide #(.ACCM_W(ACCM_W)) u_esc (
        .byte_i(esc_byte),
        .accm_i(accm),
        .esc_o (esc_need)
    );

    hdlc_fcs_unit u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .init_i(fcs_init),
        .upd_i (fcs_upd),
        .byte_i(in_data),
        .fcs_o (fcs)
    );

    assign fcs_inv = ~fcs;

    always_comb begin
        case (r_q.st)
            ST_FCSL: esc_byte = fcs_inv[7:0];
            ST_FCSH: esc_byte = fcs_inv[15:8];
            default: esc_byte = in_data;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.rej   = 1'b0;
        out_valid = 1'b0;
        out_data  = FLAG_OCT;
        in_ready  = 1'b0;
        fcs_init  = 1'b0;
        fcs_upd   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (in_len > mru) r_d.st = ST_DRAIN;
                    else              r_d.st = ST_OPEN;
                end
            end
            ST_OPEN: begin
                out_valid = 1'b1;
                out_data  = FLAG_OCT;
                if (out_ready) begin
                    fcs_init = 1'b1;
                    r_d.st   = ST_DATA;
                end
            end
            ST_DATA: begin
                out_valid = in_valid;
                out_data  = esc_need ? ESC_OCT : in_data;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    fcs_upd = 1'b1;
                    if (esc_need) begin
                        r_d.hold = in_data ^ XOR_MASK;
                        r_d.ret  = in_last ? ST_FCSL : ST_DATA;
                        r_d.st   = ST_ESC2;
                    end else begin
                        r_d.st   = in_last ? ST_FCSL : ST_DATA;
                    end
                end
            end
            ST_ESC2: begin
                out_valid = 1'b1;
                out_data  = r_q.hold;
                if (out_ready) r_d.st = r_q.ret;
            end
            ST_FCSL, ST_FCSH: begin
                out_valid = 1'b1;
                out_data  = esc_need ? ESC_OCT : esc_byte;
                if (out_ready) begin
                    if (esc_need) begin
                        r_d.hold = esc_byte ^ XOR_MASK;
                        r_d.ret  = (r_q.st == ST_FCSL) ? ST_FCSH : ST_CLOSE;
                        r_d.st   = ST_ESC2;
                    end else begin
                        r_d.st   = (r_q.st == ST_FCSL) ? ST_FCSH : ST_CLOSE;
                    end
                end
            end
            ST_CLOSE: begin
                out_valid = 1'b1;
                out_data  = FLAG_OCT;
                if (out_ready) r_d.st = ST_IDLE;
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    r_d.st  = ST_IDLE;
                    r_d.rej = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.ret  <= ST_IDLE;
            r_q.hold <= 8'h00;
            r_q.rej  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reject = r_q.rej;

    // output held steady under backpressure in every register-driven state
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && r_q.st != ST_DATA) |=> (out_valid && $stable(out_data)));

    // the second half of a pair is entered only right after an accepted escape octet
    assert_pair_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ESC2 && $past(r_q.st) != ST_ESC2)
            |-> $past(out_valid && out_ready && out_data == ESC_OCT));

    // the transformed octet can never itself look like a flag or escape
    assert_pair_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ESC2) |-> (out_data != FLAG_OCT && out_data != ESC_OCT));

    assert_drain_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DRAIN) |-> !out_valid);

    assert_reject_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> ($past(r_q.st) == ST_DRAIN && !out_valid));

endmodule

// File: tb/sim_hdlc_async_framer.sv
module sim_hdlc_async_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_accm_we = 1'b0;
    logic [31:0] cfg_accm = '0;
    logic        cfg_mru_we = 1'b0;
    logic [15:0] cfg_mru = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [15:0] in_len = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        reject;

    hdlc_async_framer u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_accm_we(cfg_accm_we), .cfg_accm(cfg_accm),
        .cfg_mru_we(cfg_mru_we), .cfg_mru(cfg_mru),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_len(in_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .reject(reject)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int stall_pct = 0;
    int gcount = 0;
    int rcount = 0;
    int ecount = 0;
    logic [31:0] cur_accm = 32'hFFFF_FFFF;
    logic [7:0]  pkt [0:63];
    logic [7:0]  expv [0:255];
    logic [7:0]  got [0:255];
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // random backpressure, driven away from the edge
    always begin
        @(posedge clk);
        #2;
        out_ready = (($urandom % 100) >= 32'(stall_pct));
    end

    // monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                // R9: stalled octet must still be offered unchanged
                chk(out_valid && out_data == prev_data, "R9 stall hold",
                    {23'b0, out_valid, out_data}, {24'h1, prev_data});
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (gcount < 256) got[gcount] = out_data;
                gcount++;
            end
            if (reject) rcount++;
        end
    end

    function automatic logic [15:0] ref_fcs(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x;
        x = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
        return x;
    endfunction

    function automatic bit needs_esc(input logic [7:0] b, input logic [31:0] m);
        return (b < 8'h20 && m[b[4:0]]) || b == 8'h7E || b == 8'h7D;
    endfunction

    task automatic push_oct(input logic [7:0] b);
        if (needs_esc(b, cur_accm)) begin
            expv[ecount] = 8'h7D;
            expv[ecount+1] = b ^ 8'h20;
            ecount += 2;
        end else begin
            expv[ecount] = b;
            ecount++;
        end
    endtask

    task automatic build_expect(input int n);
        logic [15:0] f;
        ecount = 0;
        expv[0] = 8'h7E;
        ecount = 1;
        f = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            f = ref_fcs(f, pkt[i]);
            push_oct(pkt[i]);
        end
        f = ~f;
        push_oct(f[7:0]);
        push_oct(f[15:8]);
        expv[ecount] = 8'h7E;
        ecount++;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic write_accm(input logic [31:0] v);
        cfg_accm_we = 1'b1;
        cfg_accm = v;
        step();
        cfg_accm_we = 1'b0;
        cur_accm = v;
    endtask

    task automatic write_mru(input logic [15:0] v);
        cfg_mru_we = 1'b1;
        cfg_mru = v;
        step();
        cfg_mru_we = 1'b0;
    endtask

    task automatic send_pkt(input int n, input logic [15:0] lenf);
        for (int i = 0; i < n; i++) begin
            bit acc;
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_last  = (i == n - 1);
            in_len   = lenf;
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                acc = in_ready;
                step();
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // send a packet that must be framed and compare the whole frame
    task automatic run_frame(input int n, input logic [15:0] lenf, input string tag);
        int errs;
        int first_bad;
        gcount = 0;
        rcount = 0;
        build_expect(n);
        send_pkt(n, lenf);
        for (int w = 0; w < 600 && gcount < ecount; w++) step();
        repeat (6) step();
        chk(gcount == ecount, {tag, " frame length"}, gcount, ecount);
        errs = 0;
        first_bad = 0;
        for (int i = 0; i < ecount && i < gcount; i++) begin
            if (got[i] !== expv[i]) begin
                if (errs == 0) first_bad = i;
                errs++;
            end
        end
        chk(errs == 0, {tag, " frame content"}, int'(got[first_bad]), int'(expv[first_bad]));
        chk(rcount == 0, {tag, " no reject"}, rcount, 0);
    endtask

    task automatic run_reject(input int n, input logic [15:0] lenf, input string tag);
        gcount = 0;
        rcount = 0;
        send_pkt(n, lenf);
        repeat (6) step();
        chk(gcount == 0, {tag, " no output"}, gcount, 0);
        chk(rcount == 1, {tag, " reject pulse"}, rcount, 1);
    endtask

    initial begin
        void'($urandom(32'd20251));
        repeat (5) step();
        @(negedge clk);
        // R8: reset state
        chk(!out_valid, "R8 out_valid after reset", out_valid, 0);
        chk(!reject, "R8 reject after reset", reject, 0);
        chk(!in_ready, "R8 in_ready after reset", in_ready, 0);
        step();
        rst_n = 1'b1;
        repeat (2) step();

        // R8, R2: default mask escapes control octets
        pkt[0] = 8'h01; pkt[1] = 8'h41; pkt[2] = 8'h1F;
        run_frame(3, 16'd3, "R8 default mask");
        chk(expv[1] == 8'h7D && expv[2] == 8'h21, "R2 escape pair model", expv[2], 8'h21);

        // R8: default maximum length 1500 (equal passes, above rejected)
        pkt[0] = 8'h55; pkt[1] = 8'hAA;
        run_frame(2, 16'd1500, "R8 R7 length 1500");
        run_reject(2, 16'd1501, "R8 R6 length 1501");

        // R4: known check value, mask cleared (R11 write takes effect)
        write_accm(32'h0);
        for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
        run_frame(9, 16'd9, "R4 R11 digits");
        chk(got[10] == 8'h6E, "R4 trailer low", got[10], 8'h6E);
        chk(got[11] == 8'h90, "R4 trailer high", got[11], 8'h90);

        // R3: flag and escape always stuffed with empty mask; R2 raw control
        pkt[0] = 8'h7E; pkt[1] = 8'h7D; pkt[2] = 8'h05; pkt[3] = 8'h7E;
        run_frame(4, 16'd4, "R3 R2 forced escapes");
        chk(got[1] == 8'h7D && got[2] == 8'h5E, "R3 flag stuffed", got[2], 8'h5E);

        // R2, R10: sparse mask over a sweep of octets
        write_accm(32'h8000_A00A);
        for (int i = 0; i < 48; i++) pkt[i] = 8'(i);
        run_frame(48, 16'd48, "R2 R10 sweep low");
        write_accm(32'hFFFF_FFFF);
        for (int i = 0; i < 48; i++) pkt[i] = 8'h50 + 8'(i);
        run_frame(48, 16'd48, "R10 R3 sweep high");

        // R5: find a one-octet packet whose trailer needs escaping
        begin
            int found;
            found = -1;
            for (int v = 8'h20; v < 8'h7C && found < 0; v++) begin
                logic [15:0] f;
                f = ~ref_fcs(16'hFFFF, 8'(v));
                if (needs_esc(f[7:0], 32'hFFFF_FFFF) || needs_esc(f[15:8], 32'hFFFF_FFFF))
                    found = v;
            end
            chk(found >= 0, "R5 candidate found", found, 0);
            if (found >= 0) begin
                pkt[0] = 8'(found);
                run_frame(1, 16'd1, "R5 escaped trailer");
                chk(ecount > 5, "R5 trailer stuffed", ecount, 6);
            end
        end

        // R6, R7 with a small maximum length, under backpressure
        write_mru(16'd8);
        stall_pct = 40;
        for (int i = 0; i < 9; i++) pkt[i] = 8'h7E;
        run_reject(9, 16'd9, "R6 oversize");
        run_frame(8, 16'd8, "R7 at limit");
        write_mru(16'd1500);

        // R9, R1: random packets with random stalls and masks
        for (int k = 0; k < 24; k++) begin
            int n;
            write_accm($urandom);
            n = 1 + int'($urandom % 40);
            for (int i = 0; i < n; i++) begin
                case ($urandom % 4)
                    0: pkt[i] = 8'($urandom % 32);
                    1: pkt[i] = ($urandom % 2) ? 8'h7E : 8'h7D;
                    default: pkt[i] = 8'($urandom);
                endcase
            end
            stall_pct = int'($urandom % 70);
            run_frame(n, 16'(n), "R9 R1 random");
        end

        stall_pct = 0;
        repeat (4) step();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule